// File: doc/BRIEF.md
# Read-Side Width and Byte-Order Converter

This block sits between the storage of a 36-bit FIFO and its read port. Each stored long word is held in a register and handed out on the read port as a single 36-bit long word, as two 18-bit words, or as four 9-bit bytes. Two static inputs select the width. A byte-order bit is sampled while reset is asserted and decides whether the most significant or the least significant part of each long word comes out first.

Toward the storage the block uses a valid/ready handshake and takes one long word at a time. Toward the reader it offers `outValid` and accepts a read-enable. Each enabled read consumes one part. A new long word is taken from storage only when the holding register is empty or its final part is being read. That lets a continuously enabled reader stream without gaps.

Top module: `busmatch_rd`

## Requirements
- R1: While `rstN` is low and in the first cycle after it is released, `outValid` is 0 and `fifoReady` is 1.
- R2: With `busMatch` = 0 (long mode), each accepted long word is delivered whole on `outData[35:0]` by one enabled read.
- R3: With `busMatch` = 1 and `sizeSel` = 0 (word mode), each long word is delivered by two enabled reads of 18 bits on `outData[17:0]`, and `outData[35:18]` is 0 whenever `outValid` is 1.
- R4: With `busMatch` = 1 and `sizeSel` = 1 (byte mode), each long word is delivered by four enabled reads of 9 bits on `outData[8:0]`, and `outData[35:9]` is 0 whenever `outValid` is 1.
- R5: If `endianPin` was 0 at the last clock edge of reset, parts are delivered from least significant (bits 8:0 or 17:0) to most significant.
- R6: If `endianPin` was 1 at the last clock edge of reset, parts are delivered from most significant (bits 35:27 or 35:18) to least significant.
- R7: Changes on `endianPin` after reset has been released have no effect on the delivery order.
- R8: `fifoReady` is 0 while a held long word still has unread parts and `rdEn` is 0, so no new long word is taken before the final part of the current one is read.
- R9: While `outValid` is 1 and `rdEn` is 0, `outData` and `outValid` hold their values at the next edge and no part is consumed.
- R10: With `rdEn` held at 1 and storage always valid, one part is delivered every cycle, including across long-word boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| endianPin | input | 1 | Byte-order select, sampled only while `rstN` is low (1 = most significant first) |
| busMatch | input | 1 | 0 selects long mode, 1 selects a narrow mode |
| sizeSel | input | 1 | In a narrow mode: 1 selects bytes, 0 selects words |
| fifoData | input | 36 | Long word offered by storage |
| fifoValid | input | 1 | Storage has a long word on `fifoData` |
| fifoReady | output | 1 | Long word is taken at this edge when `fifoValid` is 1 |
| rdEn | input | 1 | Reader consumes the current part at this edge |
| outValid | output | 1 | `outData` carries a valid part |
| outData | output | 36 | Current part, zero-extended |

## Verification
If the part counter or the held byte order is corrupted, the very next enabled read puts a slice from the wrong lane onto `outData`. The scoreboard compares every consumed part with its expected value, so a wrong slice is reported in the cycle it appears. If the holding flag or the fetch condition is wrong, a long word is either overwritten while it still has unread parts or never released. The first case shows up on the next read as a part from the following word. The second shows up as the stream stalling until the watchdog expires. A zero-extension fault shows up as nonzero upper bits on the first narrow read.

// File: rtl/busmatch_pkg.sv
package busmatch_pkg;
  localparam int LANE_W  = 9;
  localparam int LANES   = 4;
  localparam int PART_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    MODE_LONG = 2'd0,
    MODE_WORD = 2'd1,
    MODE_BYTE = 2'd2
  } widthMode_t;

  typedef struct packed {
    logic              loadHold;
    widthMode_t        mode;
    logic [PART_W-1:0] partIdx;
  } dpStrobe_t;
endpackage

// File: rtl/busmatch_ctrl.sv
module busmatch_ctrl
  import busmatch_pkg::*;
#(
  parameter int NUM_LANES = LANES
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      endianPin,
  input  logic      busMatch,
  input  logic      sizeSel,
  input  logic      fifoValid,
  input  logic      rdEn,
  output logic      fifoReady,
  output logic      outValid,
  output dpStrobe_t strobe
);
  localparam logic [PART_W-1:0] LAST_BYTE = PART_W'(NUM_LANES - 1);
  localparam logic [PART_W-1:0] LAST_WORD = PART_W'(NUM_LANES / 2 - 1);

  logic              bigEnd;
  logic              holdValid;
  logic [PART_W-1:0] partCnt;
  logic [PART_W-1:0] lastIdx;
  widthMode_t        mode;
  logic              fire;
  logic              atLast;
  logic              fetch;

  always_comb begin
    if (!busMatch) begin
      mode    = MODE_LONG;
      lastIdx = '0;
    end else if (sizeSel) begin
      mode    = MODE_BYTE;
      lastIdx = LAST_BYTE;
    end else begin
      mode    = MODE_WORD;
      lastIdx = LAST_WORD;
    end
  end

  assign fire      = rdEn && holdValid;
  assign atLast    = (partCnt == lastIdx);
  assign fetch     = !holdValid || (fire && atLast);
  assign fifoReady = fetch;
  assign outValid  = holdValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bigEnd    <= endianPin;
      holdValid <= 1'b0;
      partCnt   <= '0;
    end else begin
      if (fetch && fifoValid)  holdValid <= 1'b1;
      else if (fire && atLast) holdValid <= 1'b0;
      if (fire) partCnt <= atLast ? '0 : partCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.loadHold = fetch && fifoValid;
    strobe.mode     = mode;
    strobe.partIdx  = bigEnd ? (lastIdx - partCnt) : partCnt;
  end

  AST_ORDER_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> $stable(bigEnd)); // R7

  AST_NO_EARLY_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !rdEn) |-> !fifoReady); // R8

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    partCnt <= lastIdx); // R8
endmodule

// File: rtl/busmatch_datapath.sv
module busmatch_datapath
  import busmatch_pkg::*;
#(
  parameter int LANE_BITS = LANE_W,
  parameter int NUM_LANES = LANES
) (
  input  logic                           clk,
  input  logic [LANE_BITS*NUM_LANES-1:0] fifoData,
  input  dpStrobe_t                      strobe,
  output logic [LANE_BITS*NUM_LANES-1:0] outData
);
  localparam int LONG_W = LANE_BITS * NUM_LANES;
  localparam int WORD_W = LONG_W / 2;

  logic [LONG_W-1:0] holdReg;

  always_ff @(posedge clk) begin
    if (strobe.loadHold) holdReg <= fifoData;
  end

  always_comb begin
    outData = '0;
    case (strobe.mode)
      MODE_WORD: outData[WORD_W-1:0]    = holdReg[int'(strobe.partIdx)*WORD_W +: WORD_W];
      MODE_BYTE: outData[LANE_BITS-1:0] = holdReg[int'(strobe.partIdx)*LANE_BITS +: LANE_BITS];
      default:   outData                = holdReg;
    endcase
  end
endmodule

// File: rtl/busmatch_rd.sv
module busmatch_rd
  import busmatch_pkg::*;
#(
  parameter int LANE_BITS = LANE_W,
  parameter int NUM_LANES = LANES
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           endianPin,
  input  logic                           busMatch,
  input  logic                           sizeSel,
  input  logic [LANE_BITS*NUM_LANES-1:0] fifoData,
  input  logic                           fifoValid,
  output logic                           fifoReady,
  input  logic                           rdEn,
  output logic                           outValid,
  output logic [LANE_BITS*NUM_LANES-1:0] outData
);
  localparam int LONG_W = LANE_BITS * NUM_LANES;
  localparam int WORD_W = LONG_W / 2;

  dpStrobe_t strobe;

  busmatch_ctrl #(.NUM_LANES(NUM_LANES)) ctrl (
    .clk(clk), .rstN(rstN), .endianPin(endianPin), .busMatch(busMatch),
    .sizeSel(sizeSel), .fifoValid(fifoValid), .rdEn(rdEn),
    .fifoReady(fifoReady), .outValid(outValid), .strobe(strobe)
  );

  busmatch_datapath #(.LANE_BITS(LANE_BITS), .NUM_LANES(NUM_LANES)) dpath (
    .clk(clk), .fifoData(fifoData), .strobe(strobe), .outData(outData)
  );

  AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && busMatch && !sizeSel) |-> (outData[LONG_W-1:WORD_W] == '0)); // R3

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && busMatch && sizeSel) |-> (outData[LONG_W-1:LANE_BITS] == '0)); // R4

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !rdEn) |=> (outValid && $stable(outData))); // R9
endmodule

// File: tb/busmatch_rd_test.sv
module busmatch_rd_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        endianPin = 1'b0;
  logic        busMatch = 1'b0;
  logic        sizeSel = 1'b0;
  logic [35:0] fifoData = '0;
  logic        fifoValid = 1'b0;
  logic        fifoReady;
  logic        rdEn = 1'b0;
  logic        outValid;
  logic [35:0] outData;

  int          checks = 0;
  int          errors = 0;
  int          rdMode = 0;
  logic        expBig = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [35:0] expQ[$];
  string       curReq = "R2";

  busmatch_rd uut (
    .clk(clk), .rstN(rstN), .endianPin(endianPin), .busMatch(busMatch),
    .sizeSel(sizeSel), .fifoData(fifoData), .fifoValid(fifoValid),
    .fifoReady(fifoReady), .rdEn(rdEn), .outValid(outValid), .outData(outData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pushExpected(input logic [35:0] w);
    int n;
    n = !busMatch ? 1 : (sizeSel ? 4 : 2);
    for (int k = 0; k < n; k++) begin
      int idx;
      idx = expBig ? (n - 1 - k) : k;
      if (n == 1)      expQ.push_back(w);
      else if (n == 2) expQ.push_back({18'b0, w[idx*18 +: 18]});
      else             expQ.push_back({27'b0, w[idx*9 +: 9]});
    end
  endtask

  task automatic sendWord(input logic [35:0] w);
    pushExpected(w);
    @(negedge clk);
    fifoValid = 1'b1;
    fifoData  = w;
    #1;
    while (!fifoReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    fifoValid = 1'b0;
  endtask

  task automatic doReset(input logic e);
    @(negedge clk);
    rstN = 1'b0;
    endianPin = e;
    expBig = e;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset outValid", {35'b0, outValid}, 36'd0);
    check("R1 reset fifoReady", {35'b0, fifoReady}, 36'd1);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check("R1 after release outValid", {35'b0, outValid}, 36'd0);
    check("R1 after release fifoReady", {35'b0, fifoReady}, 36'd1);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: choose rdEn at each falling edge, then compare the part that the next edge consumes
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdEn = (rdMode == 1) ? 1'b1 : (rdMode == 2) ? lfsr[0] : 1'b0;
      #1;
      if (rstN && outValid && rdEn) begin
        if (expQ.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL %s: actual %h expected nothing", curReq, outData);
        end else begin
          check(curReq, outData, expQ.pop_front());
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [35:0] first;
    int streamCycles;

    // little-endian phase
    busMatch = 1'b0; sizeSel = 1'b0;
    doReset(1'b0);
    rdMode = 2;
    curReq = "R2 long LE";
    for (int i = 0; i < 6; i++) sendWord(36'h9_8765_4321 + 36'(i) * 36'h1_1111_1111);
    drain();

    busMatch = 1'b1; sizeSel = 1'b0;
    curReq = "R3 R5 word LE";
    for (int i = 0; i < 6; i++) sendWord(36'hF_0123_ABCD ^ (36'(i) << 5));
    drain();

    busMatch = 1'b1; sizeSel = 1'b1;
    curReq = "R4 R5 byte LE";
    for (int i = 0; i < 6; i++) sendWord(36'h1_2345_6789 + 36'(i) * 36'h0_0402_0101);
    drain();

    // R7: pin changes after reset must not alter order
    endianPin = 1'b1;
    curReq = "R7 byte order kept";
    for (int i = 0; i < 3; i++) sendWord(36'hA_5A5A_5A5A ^ 36'(i * 77));
    drain();

    // R8 / R9: stall with data held and a second word offered
    rdMode = 0;
    sendWord(36'h8_0402_0100);
    @(negedge clk);
    fifoValid = 1'b1;
    fifoData  = 36'h7_7777_7777;
    #1;
    first = outData;
    check("R4 R5 first byte while stalled", first, 36'h000_0000_00 | 36'h100);
    for (int i = 0; i < 4; i++) begin
      check("R8 no fetch while parts remain", {35'b0, fifoReady}, 36'd0);
      check("R9 output held", outData, first);
      check("R9 valid held", {35'b0, outValid}, 36'd1);
      @(negedge clk);
      #1;
    end
    fifoValid = 1'b0;
    curReq = "R8 R9 after stall";
    rdMode = 1;
    drain();

    // big-endian phase
    busMatch = 1'b1; sizeSel = 1'b1;
    rdMode = 0;
    doReset(1'b1);
    endianPin = 1'b0;
    rdMode = 2;
    curReq = "R4 R6 byte BE";
    for (int i = 0; i < 6; i++) sendWord(36'h1_2345_6789 + 36'(i) * 36'h0_0402_0101);
    drain();

    busMatch = 1'b1; sizeSel = 1'b0;
    curReq = "R3 R6 word BE";
    for (int i = 0; i < 6; i++) sendWord(36'hC_3C3C_1234 ^ (36'(i) << 9));
    drain();

    busMatch = 1'b0;
    curReq = "R2 long BE";
    for (int i = 0; i < 4; i++) sendWord(36'h5_5555_AAAA + 36'(i));
    drain();

    // R10: continuous stream in byte mode, one part every cycle
    busMatch = 1'b1; sizeSel = 1'b1;
    rdMode = 1;
    curReq = "R10 stream";
    pushExpected(36'h1_0203_0405);
    pushExpected(36'h6_0708_090A);
    pushExpected(36'hB_0C0D_0E0F);
    @(negedge clk);
    fifoValid = 1'b1;
    fifoData  = 36'h1_0203_0405;
    streamCycles = 0;
    for (int w = 0; w < 3; w++) begin
      #1;
      while (!fifoReady) begin
        @(negedge clk);
        #1;
        streamCycles++;
      end
      @(posedge clk);
      #1;
      fifoData = (w == 0) ? 36'h6_0708_090A : 36'hB_0C0D_0E0F;
      if (w == 2) fifoValid = 1'b0;
      @(negedge clk);
      streamCycles++;
    end
    drain();
    check("R10 no bubbles across words", 36'(streamCycles), 36'd9);

    rdMode = 0;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule